// File: doc/BRIEF.md
# Broadcast Doorbell Write Fan-out Bridge

This bridge sits on the slave side of a register bus. A host write sent to a DMA queue window is copied to several DMA engine register ports in one transaction. A software-written participation bitmap has one bit per die-and-engine slot, and it picks which engine ports receive the copy. The write data is the doorbell count N. Every selected port receives the same count and the same offset inside the queue sub-window, both left as the host sent them.

The bridge decodes the 48-bit host address. Bit 47 picks die 0 or die 1. On each die, four engine windows sit at 0x001002000000, 0x001003000000, 0x005004000000 and 0x005005000000, and die 1 uses these bases with bit 47 set. The queue registers start 0x80000 above each base. Each selected target acknowledges on its own, in any order. The host sees one completion pulse, and only after the last selected target has acknowledged. Only one transaction can be in flight at a time.

Top module: `bcast_doorbell_fanout`

## Requirements
- R1: After reset the participation bitmap is zero. A cycle with `cfg_wr` high loads `cfg_map` into it, and bit i of the bitmap enables target port i.
- R2: An address is accepted only if two things hold. Bits 46:24 must equal one of the four engine window bases, with bit 47 free to pick either die. Bits 23:19 must equal 1, meaning the address lies 0x80000 to 0xFFFFF above that base. Any other address gets an error response and drives no target.
- R3: `tgt_offset` carries address bits 18:0 and `tgt_wdata` carries the host data, both unchanged and held steady for the whole transaction.
- R4: An accepted write raises `tgt_valid[i]` for every bitmap bit i that is set, and for no other bit, in the cycle after the request is accepted.
- R5: `tgt_valid[i]` stays high until a clock edge at which `tgt_ready[i]` is high, and it drops after that edge.
- R6: `host_ready` rises with `host_err` low only after every selected target has acknowledged, in whatever order the acknowledgements arrive. It rises in the cycle after the last acknowledgement.
- R7: A write accepted while the bitmap is zero gets `host_ready` with `host_err` high in the cycle after acceptance, and drives no target.
- R8: The bitmap is captured when a request is accepted. A configuration write during the transaction does not change which targets that transaction drives.
- R9: `host_ready` is a one-cycle pulse. The bridge accepts the next request only after that pulse, so only one transaction is in flight.
- R10: While reset is held and right after it, `tgt_valid` and `host_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load the participation bitmap |
| cfg_map | input | 8 | New bitmap value |
| host_valid | input | 1 | Host write request, held until `host_ready` |
| host_addr | input | 48 | Host device address |
| host_wdata | input | 32 | Doorbell count N |
| host_ready | output | 1 | Completion pulse |
| host_err | output | 1 | Error flag, valid with `host_ready` |
| tgt_valid | output | 8 | Per-target write request |
| tgt_offset | output | 19 | Offset inside the queue sub-window |
| tgt_wdata | output | 32 | Forwarded doorbell count |
| tgt_ready | input | 8 | Per-target acknowledge |

## Verification
Some internal faults would show up at the ports within one or two cycles of the fault:
- A pending-target bit that was loaded or cleared wrongly would leave a `tgt_valid` high after its acknowledge, or missing from the start.
- Such a bit could also produce a `host_ready` that comes before all selected targets have acknowledged, or never comes at all.
- A wrong window comparison would turn a valid address into an error response, or the reverse, in the cycle after acceptance.
- A capture enable that failed would change `tgt_offset` or `tgt_wdata` in the middle of a transaction.

The bench works through all nonzero bitmaps with staggered acknowledge delays, all eight windows, bad addresses, an empty bitmap, and bitmap rewrites during a transaction.

// File: rtl/bdf_pkg.sv
package bdf_pkg;
  localparam int ADDR_W      = 48;
  localparam int NUM_DIES    = 2;
  localparam int ENG_PER_DIE = 4;
  localparam int NUM_TGT     = NUM_DIES * ENG_PER_DIE;
  localparam int WIN_LSB     = 24;   // engine window granularity
  localparam int QOFF_W      = 19;   // queue sub-window size 0x80000
  localparam int QSUB_IDX    = 1;    // sub-window sits at +0x80000

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_RESP} bdf_state_e;

  // die-0 engine window bases
  function automatic logic [ADDR_W-1:0] eng_base(input int e);
    case (e)
      0:       eng_base = 48'h0010_0200_0000;
      1:       eng_base = 48'h0010_0300_0000;
      2:       eng_base = 48'h0050_0400_0000;
      default: eng_base = 48'h0050_0500_0000;
    endcase
  endfunction
endpackage

// File: rtl/bdf_addr_decode.sv
module bdf_addr_decode
  import bdf_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int NENG = ENG_PER_DIE,
  parameter int OFFW = QOFF_W,
  parameter int WLSB = WIN_LSB
) (
  input  logic [AW-1:0]   addr,
  output logic            hit,
  output logic [OFFW-1:0] offset
);
  localparam int SUBW = WLSB - OFFW;

  logic [NENG-1:0] match;
  logic            in_sub;

  assign in_sub = (addr[WLSB-1:OFFW] == SUBW'(QSUB_IDX));

  for (genvar e = 0; e < NENG; e++) begin : g_win
    localparam logic [AW-1:0] BASE = eng_base(e);
    assign match[e] = (addr[AW-2:WLSB] == BASE[AW-2:WLSB]);
  end

  assign hit    = in_sub && (|match);
  assign offset = addr[OFFW-1:0];

  always_comb begin
    assert_windows_disjoint_R2: assert ($onehot0(match));
  end
endmodule

// File: rtl/bdf_ack_tracker.sv
module bdf_ack_tracker #(
  parameter int NT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NT-1:0] load_map,
  input  logic [NT-1:0] ack,
  output logic [NT-1:0] pending,
  output logic          all_done
);
  logic [NT-1:0] pending_d;

  always_comb begin
    pending_d = pending;
    if (load) pending_d = load_map;
    else      pending_d = pending & ~ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= pending_d;
  end

  assign all_done = ((pending & ~ack) == '0);

  for (genvar i = 0; i < NT; i++) begin : g_chk
    assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pending[i] && !ack[i] && !load) |=> pending[i]);
    assert_clear_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pending[i] && ack[i] && !load) |=> !pending[i]);
  end
endmodule

// File: rtl/bcast_doorbell_fanout.sv
module bcast_doorbell_fanout
  import bdf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NT     = NUM_TGT,
  parameter int AW     = ADDR_W,
  parameter int OFFW   = QOFF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [NT-1:0]   cfg_map,
  input  logic            host_valid,
  input  logic [AW-1:0]   host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic            host_ready,
  output logic            host_err,
  output logic [NT-1:0]   tgt_valid,
  output logic [OFFW-1:0] tgt_offset,
  output logic [DATA_W-1:0] tgt_wdata,
  input  logic [NT-1:0]   tgt_ready
);
  bdf_state_e        state, state_d;
  logic [NT-1:0]     map_q;
  logic              err_q;
  logic [OFFW-1:0]   off_q;
  logic [DATA_W-1:0] data_q;
  logic              dec_hit;
  logic [OFFW-1:0]   dec_off;
  logic              accept, bad, launch, all_done;

  bdf_addr_decode #(.AW(AW), .NENG(ENG_PER_DIE), .OFFW(OFFW), .WLSB(WIN_LSB)) u_dec (
    .addr   (host_addr),
    .hit    (dec_hit),
    .offset (dec_off)
  );

  assign accept = (state == ST_IDLE) && host_valid;
  assign bad    = !dec_hit || (map_q == '0);
  assign launch = accept && !bad;

  bdf_ack_tracker #(.NT(NT)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (launch),
    .load_map (map_q),
    .ack      (tgt_ready),
    .pending  (tgt_valid),
    .all_done (all_done)
  );

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE: if (accept) state_d = bad ? ST_RESP : ST_BUSY;
      ST_BUSY: if (all_done) state_d = ST_RESP;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      map_q <= '0;
    else if (cfg_wr) map_q <= cfg_map;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (accept) err_q <= bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      data_q <= '0;
    end else if (launch) begin
      off_q  <= dec_off;
      data_q <= host_wdata;
    end
  end

  assign host_ready = (state == ST_RESP);
  assign host_err   = (state == ST_RESP) && err_q;
  assign tgt_offset = off_q;
  assign tgt_wdata  = data_q;

  assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);
  assert_empty_map_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && map_q == '0) |=> (host_ready && host_err));
  assert_no_target_on_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ready && host_err) |-> (tgt_valid == '0));
  assert_payload_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_BUSY) && $past(state == ST_BUSY)) |-> ($stable(tgt_wdata) && $stable(tgt_offset)));
  assert_ok_after_all_acks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && (tgt_valid & ~tgt_ready) != '0) |=> !host_ready);
endmodule

// File: tb/bcast_doorbell_fanout_test.sv
`timescale 1ns/1ps
module bcast_doorbell_fanout_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [7:0]  cfg_map;
  logic        host_valid;
  logic [47:0] host_addr;
  logic [31:0] host_wdata;
  logic        host_ready, host_err;
  logic [7:0]  tgt_valid;
  logic [18:0] tgt_offset;
  logic [31:0] tgt_wdata;
  logic [7:0]  tgt_ready;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  bcast_doorbell_fanout uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_map(cfg_map),
    .host_valid(host_valid), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_err(host_err), .tgt_valid(tgt_valid),
    .tgt_offset(tgt_offset), .tgt_wdata(tgt_wdata), .tgt_ready(tgt_ready)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] win_addr(input int w, input logic [18:0] off);
    logic [47:0] b;
    case (w % 4)
      0: b = 48'h0010_0200_0000;
      1: b = 48'h0010_0300_0000;
      2: b = 48'h0050_0400_0000;
      default: b = 48'h0050_0500_0000;
    endcase
    if (w >= 4) b[47] = 1'b1;
    return b + 48'h80000 + {29'd0, off};
  endfunction

  task automatic set_map(input logic [7:0] m);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_map = m;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // One host write; expm = expected target set, experr = expected error.
  // seed sets per-target acknowledge delays; newmap != 0 rewrites bitmap mid-flight.
  task automatic run_txn(input logic [47:0] a, input logic [31:0] d,
                         input logic [7:0] expm, input bit experr,
                         input int seed, input logic [7:0] newmap);
    logic [7:0] seen, acked;
    int wait_c [8];
    int n;
    bit done;
    seen = '0; acked = '0; done = 0; n = 0;
    for (int i = 0; i < 8; i++) wait_c[i] = 0;
    @(negedge clk);
    host_valid = 1'b1; host_addr = a; host_wdata = d; tgt_ready = '0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
      cfg_wr = (n == 2 && newmap != 0);
      cfg_map = newmap;
      if (n == 1 && !experr)
        chk(tgt_valid == expm, "R4 fan-out set", tgt_valid, expm);
      for (int i = 0; i < 8; i++) begin
        if (tgt_valid[i]) begin
          if (acked[i]) chk(0, "R5 valid after ack", i, 0);
          if (!expm[i] || experr) chk(0, "R8 unexpected target", i, 0);
          seen[i] = 1'b1;
        end
      end
      if (tgt_valid != 0) begin
        chk(tgt_offset == a[18:0], "R3 offset", tgt_offset, a[18:0]);
        chk(tgt_wdata == d, "R3 data", tgt_wdata, d);
      end
      if (host_ready) begin
        done = 1;
        chk(host_err == experr, "R6/R7 error flag", host_err, experr);
        if (!experr) chk(acked == expm, "R6 all acked", acked, expm);
        else chk(n == 1, "R7 immediate response", n, 1);
      end else begin
        for (int i = 0; i < 8; i++) begin
          if (tgt_valid[i] && !acked[i]) begin
            wait_c[i]++;
            if (wait_c[i] > ((seed + 3 * i) % 5)) begin
              tgt_ready[i] = 1'b1;
              acked[i] = 1'b1;
            end else tgt_ready[i] = 1'b0;
          end else tgt_ready[i] = 1'b0;
        end
        if (acked != expm && !experr && n > 1)
          if (host_ready) chk(0, "R6 early ready", acked, expm);
      end
    end
    chk(done, "R6 completion reached", done, 1);
    chk(seen == (experr ? 8'h00 : expm), "R4/R2 targets driven", seen, experr ? 8'h00 : expm);
    host_valid = 1'b0; tgt_ready = '0; cfg_wr = 1'b0;
    @(negedge clk);
    chk(!host_ready, "R9 single pulse", host_ready, 0);
    chk(tgt_valid == 0, "R5 idle after done", tgt_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_map = '0; host_valid = 1'b0;
    host_addr = '0; host_wdata = '0; tgt_ready = '0;
    repeat (3) @(negedge clk);
    chk(tgt_valid == 0 && !host_ready, "R10 reset outputs", {tgt_valid, host_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tgt_valid == 0 && !host_ready, "R10 after release", {tgt_valid, host_ready}, 0);

    // R1/R7: bitmap is zero after reset
    run_txn(win_addr(0, 19'h10), 32'd5, 8'h00, 1'b1, 0, 8'h00);

    // R1/R4/R5/R6: every nonzero bitmap, staggered acks, rotating window
    for (int m = 1; m < 256; m++) begin
      set_map(m[7:0]);
      run_txn(win_addr(m % 8, 19'(m * 1237)), 32'(m * 77 + 1), m[7:0], 1'b0, m, 8'h00);
    end

    // R2/R3: all windows with edge offsets
    set_map(8'hA5);
    for (int w = 0; w < 8; w++) begin
      run_txn(win_addr(w, 19'h0), 32'hFFFF_FFFF, 8'hA5, 1'b0, w, 8'h00);
      run_txn(win_addr(w, 19'h7FFFF), 32'h0, 8'hA5, 1'b0, w + 2, 8'h00);
    end

    // R2: addresses outside the queue sub-windows
    run_txn(win_addr(1, 0) - 48'h1, 32'd9, 8'hA5, 1'b1, 0, 8'h00);
    run_txn(win_addr(2, 0) + 48'h80000, 32'd9, 8'hA5, 1'b1, 0, 8'h00);
    run_txn(48'h0010_0400_0000 + 48'h80000, 32'd9, 8'hA5, 1'b1, 0, 8'h00);
    run_txn(48'h0050_0200_0000 + 48'h80000, 32'd9, 8'hA5, 1'b1, 0, 8'h00);
    run_txn(win_addr(3, 0) | 48'h0000_4000_0000, 32'd9, 8'hA5, 1'b1, 0, 8'h00);

    // R8: bitmap rewritten during transactions
    set_map(8'h3C);
    run_txn(win_addr(5, 19'h123), 32'd42, 8'h3C, 1'b0, 4, 8'hC3);
    run_txn(win_addr(6, 19'h321), 32'd43, 8'hC3, 1'b0, 1, 8'hFF);
    run_txn(win_addr(7, 19'h55), 32'd44, 8'hFF, 1'b0, 3, 8'h01);

    // R7: empty bitmap after a rewrite
    set_map(8'h00);
    run_txn(win_addr(4, 19'h40), 32'd7, 8'h00, 1'b1, 0, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule